// File: doc/BRIEF.md
# DDR Burst Early-Termination Data-Path Controller

This block handles the data-path side of ending DDR SDRAM bursts before their full length. It watches the command issued each clock and produces three data-path controls. The first is a read-data-valid window, delayed by the CAS latency. The second is an enable for the write input path. The third is a data-mask output that hides the beats left over after a write burst was interrupted.

A precharge ends either kind of burst. After a precharge during a read, the data already in flight in the CAS-latency pipeline still arrives, and then the window closes. A precharge during a write closes the write input path in that same cycle and raises the mask for the write-recovery time. A burst read stop ends a read the same way a precharge does. The same stop issued during a write is not supported: the block ignores it and raises a one-cycle error flag.

Since write data is taken on both strobe edges, a burst of length BL lasts BL/2 clocks. Bank state, strobe capture and refresh are handled elsewhere.

Top module: `ddr_burst_term`

## Requirements
- R1: The command input is coded 0 = no-op, 1 = read, 2 = write, 3 = precharge, 4 = burst read stop. Codes 5 to 7 act as no-ops and do not change any output, including during a running read.
- R2: A read command issued in cycle t makes `rd_valid` high from cycle t+CL+1 for exactly BL/2 cycles. It drops in the cycle after the last beat.
- R3: A precharge in cycle p during a read burst lets `rd_valid` continue through cycle p+CL at most. From cycle p+CL+1 on it stays low.
- R4: A burst read stop in cycle s during a read burst ends `rd_valid` with the same CL delay as a precharge: low from cycle s+CL+1.
- R5: A write command issued in cycle t makes `wr_en` high from cycle t+1 for exactly BL/2 cycles, then low.
- R6: A precharge in a cycle where a write burst is active drives `wr_en` low in that same cycle, and it stays low afterwards.
- R7: In that case `dm_out` is high in the precharge cycle and the following TWR-1 cycles, for TWR cycles in total, and low otherwise.
- R8: A burst read stop during an active write burst raises `stop_err` for the single following cycle. The write burst continues unchanged.
- R9: A precharge or burst read stop with no burst active changes no output, and `dm_out` stays low.
- R10: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 3 | Command issued this cycle (coding in R1) |
| rd_valid | output | 1 | Read data valid on the data bus |
| wr_en | output | 1 | Write input path enable |
| dm_out | output | 1 | Data mask after an interrupted write |
| stop_err | output | 1 | Burst read stop issued during a write burst |

## Verification
The assertions assume the command stream never starts a read while a write burst or its mask is active, and never starts a write while read data is still in the pipeline. They also assume no new write starts while the mask is high. Under these conditions `rd_valid` and `wr_en` are never both high, and the mask never overlaps a write. The stimulus waits for every burst, its CAS-latency tail and its recovery window to drain before issuing the opposite command. Back-to-back commands of the same kind are allowed, since they only restart the beat count.

// File: rtl/ddr_bt_pkg.sv
`timescale 1ns/1ps
// Package: shared command coding for the burst termination controller.
// Assumes a 3-bit command field. Codes not listed are treated as no-ops.
package ddr_bt_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_READ  = 3'd1,
        OP_WRITE = 3'd2,
        OP_PRE   = 3'd3,
        OP_BST   = 3'd4
    } bt_op_t;
endpackage

// File: rtl/bt_beat_counter.sv
`timescale 1ns/1ps
// Module: bt_beat_counter
// Counts the clock cycles of one burst. A start loads BEATS cycles and a
// kill clears the count. If both arrive together, start wins.
// Assumes BEATS >= 1.
module bt_beat_counter #(
    parameter int BEATS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic kill,
    output logic active
);
    localparam int CW = $clog2(BEATS + 1);
    localparam logic [CW-1:0] LOAD = CW'(BEATS);

    logic [CW-1:0] left_q;

    // Purpose: load on start, clear on kill, count down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= LOAD;
        end else if (kill) begin
            left_q <= '0;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    // Purpose: burst is active while beats remain.
    always_comb active = (left_q != '0);
endmodule

// File: rtl/bt_delay_line.sv
`timescale 1ns/1ps
// Module: bt_delay_line
// Delays a single bit by DEPTH register stages. It models the
// CAS-latency path from read issue to data on the bus. Assumes DEPTH >= 1.
module bt_delay_line #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] stage_q;

    generate
        if (DEPTH == 1) begin : g_single
            // Purpose: one-stage delay.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= din;
            end
        end else begin : g_chain
            // Purpose: shift the bit one stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= {stage_q[DEPTH-2:0], din};
            end
        end
    endgenerate

    // Purpose: the last stage drives the output.
    always_comb dout = stage_q[DEPTH-1];
endmodule

// File: rtl/bt_mask_timer.sv
`timescale 1ns/1ps
// Module: bt_mask_timer
// Holds the mask high for TWR cycles, starting in the trigger cycle.
// The trigger cycle is covered combinationally and the remaining TWR-1
// cycles by a counter. Assumes TWR >= 1.
module bt_mask_timer #(
    parameter int TWR = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic mask
);
    localparam int TAIL = TWR - 1;
    localparam int CW   = (TAIL < 1) ? 1 : $clog2(TAIL + 1);
    localparam logic [CW-1:0] LOAD = CW'(TAIL);

    logic [CW-1:0] tail_q;

    // Purpose: load the remaining recovery cycles on trigger, then count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_q <= '0;
        end else if (trigger) begin
            tail_q <= LOAD;
        end else if (tail_q != '0) begin
            tail_q <= tail_q - 1'b1;
        end
    end

    // Purpose: mask is high in the trigger cycle and while the tail remains.
    always_comb mask = trigger || (tail_q != '0);
endmodule

// File: rtl/ddr_burst_term.sv
`timescale 1ns/1ps
// Module: ddr_burst_term (top)
// Data-path burst termination for a DDR SDRAM controller. It decodes the
// command of each cycle and drives the read-valid window, the write input
// enable, the interrupt data mask and the unsupported-stop flag.
// Assumes: BL is 2, 4 or 8; CL >= 1; TWR >= 1. The command stream does
// not mix read and write bursts while the other is still active.
module ddr_burst_term #(
    parameter int BL  = 8,
    parameter int CL  = 3,
    parameter int TWR = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cmd,
    output logic       rd_valid,
    output logic       wr_en,
    output logic       dm_out,
    output logic       stop_err
);
    import ddr_bt_pkg::*;

    localparam int HALF = BL / 2;

    logic is_read, is_write, is_pre, is_bst;
    logic rd_act, wr_act, wr_cut, err_q;

    // Purpose: decode the command field. Unlisted codes decode to nothing.
    always_comb begin
        is_read  = (cmd == OP_READ);
        is_write = (cmd == OP_WRITE);
        is_pre   = (cmd == OP_PRE);
        is_bst   = (cmd == OP_BST);
    end

    // Read burst: precharge or burst stop both end it at the issue stage.
    bt_beat_counter #(.BEATS(HALF)) u_rd_beats (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (is_read),
        .kill   (is_pre || is_bst),
        .active (rd_act)
    );

    // CAS-latency delay from issue stage to the data bus.
    bt_delay_line #(.DEPTH(CL)) u_rd_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rd_act),
        .dout  (rd_valid)
    );

    // Write burst: only a precharge ends it.
    bt_beat_counter #(.BEATS(HALF)) u_wr_beats (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (is_write),
        .kill   (is_pre),
        .active (wr_act)
    );

    // Purpose: a precharge hitting a live write burst is an interrupt.
    always_comb wr_cut = is_pre && wr_act;

    // Recovery mask after the interrupted write.
    bt_mask_timer #(.TWR(TWR)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (wr_cut),
        .mask    (dm_out)
    );

    // Purpose: input path closes in the very cycle of the precharge.
    always_comb wr_en = wr_act && !is_pre;

    // Purpose: flag a burst stop that arrives during a write, one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= is_bst && wr_act;
    end

    always_comb stop_err = err_q;
endmodule

// File: rtl/ddr_burst_term_chk.sv
`timescale 1ns/1ps
// Module: ddr_burst_term_chk
// Property checker bound to ddr_burst_term. It uses only the top-level
// ports, plus counters of its own for windows that depend on parameters.
module ddr_burst_term_chk #(
    parameter int BL  = 8,
    parameter int CL  = 3,
    parameter int TWR = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cmd,
    input logic       rd_valid,
    input logic       wr_en,
    input logic       dm_out,
    input logic       stop_err
);
    import ddr_bt_pkg::*;

    localparam int HALF = BL / 2;
    localparam int AW   = $clog2(CL + 2);
    localparam int RW   = $clog2(HALF + 2);
    localparam int MW   = $clog2(TWR + 2);
    localparam logic [AW-1:0] AGE_MAX = AW'(CL + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(HALF + 1);
    localparam logic [MW-1:0] MASK_MAX = MW'(TWR + 1);

    logic          cut_live;
    logic [AW-1:0] cut_age;
    logic [RW-1:0] wr_run;
    logic [MW-1:0] dm_run;

    // Purpose: age since the last read cut, cancelled by a new read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cut_live <= 1'b0;
            cut_age  <= '0;
        end else if (cmd == OP_READ) begin
            cut_live <= 1'b0;
            cut_age  <= '0;
        end else if (cmd == OP_PRE || cmd == OP_BST) begin
            cut_live <= 1'b1;
            cut_age  <= AW'(1);
        end else if (cut_live && cut_age != AGE_MAX) begin
            cut_age <= cut_age + 1'b1;
        end
    end

    // Purpose: length of the current run of write enable and of the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_run <= '0;
            dm_run <= '0;
        end else begin
            wr_run <= (wr_en && cmd != OP_WRITE && wr_run != RUN_MAX) ? wr_run + 1'b1 :
                      (wr_en ? wr_run : '0);
            dm_run <= (dm_out && dm_run != MASK_MAX) ? dm_run + 1'b1 :
                      (dm_out ? dm_run : '0);
        end
    end

    // R3/R4: once CL cycles have passed since a cut, read valid is low.
    p_rd_cut_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cut_live && cut_age == AGE_MAX) |-> !rd_valid);

    // R6: no write enable in a precharge cycle.
    p_wr_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == OP_PRE) |-> !wr_en);

    // R7: the mask never overlaps a write and never outlasts TWR cycles.
    p_dm_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dm_out |-> !wr_en);
    p_dm_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dm_out |-> (dm_run < MW'(TWR)));

    // R5: a write enable run never exceeds BL/2 cycles.
    p_wr_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_run < RW'(HALF)));

    // R8: the error flag follows a burst stop that met a write.
    p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == OP_BST && wr_en) |=> stop_err);
    p_err_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_err |-> $past(cmd == OP_BST));

    // R2/R5: read and write windows never overlap.
    p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, wr_en}));
endmodule

bind ddr_burst_term ddr_burst_term_chk #(.BL(BL), .CL(CL), .TWR(TWR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .rd_valid (rd_valid),
    .wr_en    (wr_en),
    .dm_out   (dm_out),
    .stop_err (stop_err)
);

// File: tb/ddr_burst_term_test.sv
`timescale 1ns/1ps
module ddr_burst_term_test;
    localparam int BL  = 8;
    localparam int CL  = 3;
    localparam int TWR = 2;
    localparam int HALF = BL / 2;

    localparam logic [2:0] C_NOP = 3'd0, C_RD = 3'd1, C_WR = 3'd2,
                           C_PRE = 3'd3, C_BST = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] cmd = C_NOP;
    logic rd_valid, wr_en, dm_out, stop_err;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    string cur_req = "R10";

    // Reference model state
    int rd_left = 0, wr_left = 0, dm_left = 0;
    bit err_m = 1'b0;
    bit rd_q[$];

    always #4 clk = ~clk;

    ddr_burst_term #(.BL(BL), .CL(CL), .TWR(TWR)) uut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd),
        .rd_valid(rd_valid), .wr_en(wr_en), .dm_out(dm_out), .stop_err(stop_err)
    );

    task automatic model_clear();
        rd_left = 0; wr_left = 0; dm_left = 0; err_m = 1'b0;
        rd_q.delete();
        for (int i = 0; i < CL; i++) rd_q.push_back(1'b0);
    endtask

    initial model_clear();

    // Model update on each edge, reading the command held over the edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            model_clear();
        end else begin
            rd_q.push_back(rd_left > 0);
            void'(rd_q.pop_front());
            err_m = (cmd == C_BST) && (wr_left > 0);
            if (cmd == C_PRE && wr_left > 0) dm_left = TWR - 1;
            else if (dm_left > 0) dm_left--;
            if (cmd == C_WR) wr_left = HALF;
            else if (cmd == C_PRE) wr_left = 0;
            else if (wr_left > 0) wr_left--;
            if (cmd == C_RD) rd_left = HALF;
            else if (cmd == C_PRE || cmd == C_BST) rd_left = 0;
            else if (rd_left > 0) rd_left--;
        end
    end

    task automatic check1(string name, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at %0t: actual %b expected %b", cur_req, name, $time, act, exp);
        end
    endtask

    // Compare every output on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            check1("rd_valid", rd_valid, rst_n ? rd_q[0] : 1'b0);
            check1("wr_en", wr_en, rst_n ? ((wr_left > 0) && cmd != C_PRE) : 1'b0);
            check1("dm_out", dm_out,
                   rst_n ? ((dm_left > 0) || (cmd == C_PRE && wr_left > 0)) : 1'b0);
            check1("stop_err", stop_err, rst_n ? err_m : 1'b0);
        end
    end

    task automatic send(logic [2:0] c);
        cmd = c;
        @(posedge clk); #1;
        cmd = C_NOP;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        // R10: reset holds all outputs low, even with commands applied
        cur_req = "R10";
        cmd = C_WR;
        idle(3);
        cmd = C_NOP;
        @(posedge clk); #1;
        rst_n = 1'b1;
        idle(2);

        // R2: full read burst
        cur_req = "R2";
        send(C_RD); idle(CL + HALF + 3);

        // R5: full write burst
        cur_req = "R5";
        send(C_WR); idle(HALF + 3);

        // R2: back-to-back reads restart the beat count
        cur_req = "R2";
        send(C_RD); idle(1); send(C_RD); idle(CL + HALF + 3);

        // R3: precharge interrupts a read
        cur_req = "R3";
        send(C_RD); idle(1); send(C_PRE); idle(CL + HALF + 3);

        // R4: burst read stop interrupts a read
        cur_req = "R4";
        send(C_RD); send(C_BST); idle(CL + HALF + 3);

        // R6/R7: precharge interrupts a write; mask for the recovery time
        cur_req = "R6";
        send(C_WR); idle(1);
        cur_req = "R7";
        send(C_PRE); idle(TWR + HALF + 3);

        // R7: interrupt on the last write beat
        send(C_WR); idle(HALF - 1); send(C_PRE); idle(TWR + 3);

        // R8: burst stop during a write is flagged and ignored
        cur_req = "R8";
        send(C_WR); idle(1); send(C_BST); idle(HALF + 3);

        // R9: precharge and stop with nothing active
        cur_req = "R9";
        send(C_PRE); idle(2); send(C_BST); idle(CL + 3);

        // R1: reserved codes idle and during a read
        cur_req = "R1";
        send(3'd5); send(3'd6); send(3'd7); idle(2);
        send(C_RD); send(3'd7); send(3'd5); idle(CL + HALF + 3);
        send(C_WR); send(3'd6); idle(HALF + 3);

        finish_run();
    end
endmodule